// File: doc/BRIEF.md
# Jacobian Point Addition Unit

This unit adds two points of an elliptic curve over a prime field GF(p). Both points arrive in affine form and are lifted to Jacobian projective form with Z = 1. The sum is formed from the projective chord formula on a single shared modular ALU, which does one multiply, add, subtract or halving per cycle. A short control sequence drives the ALU. The projective result is then brought back to affine form. Z⁻¹ comes from Fermat exponentiation (Z^(p−2), square-and-multiply), followed by x = X/Z² and y = Y/Z³.

A caller places the two points on the inputs and pulses `start`. Each point has a flag that marks it as the point at infinity. A flagged input makes the unit return the other operand on the next cycle. When both x coordinates are equal, the unit does not divide. If the y coordinates also match, it raises a flag saying that a doubling would be needed. If the y coordinates differ, it reports the point at infinity. The field width and the modulus are parameters. The default is a 16-bit prime.

Top module: `jac_point_adder`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done`, `r_inf`, `same_pt`, `xr` and `yr` are all 0.
- R2: For two finite points with xp ≠ xq, the completed result is the affine sum: λ = (yq − yp)/(xq − xp), xr = λ² − xp − xq, yr = λ·(xp − xr) − yp, all mod p and each below p, with both flags 0.
- R3: When `p_inf` is 1 and `q_inf` is 0, the result is (xq, yq) with both flags 0, and `done` rises on the cycle after `start`.
- R4: When `q_inf` is 1 and `p_inf` is 0, the result is (xp, yp) with both flags 0, and `done` rises on the cycle after `start`. When both are 1, the result is `r_inf` = 1 with xr = yr = 0.
- R5: For finite points with xp = xq and yp ≠ yq, the result is `r_inf` = 1, `same_pt` = 0 and xr = yr = 0.
- R6: For finite points with xp = xq and yp = yq, the result is `same_pt` = 1, `r_inf` = 0 and xr = yr = 0.
- R7: `done` is high for exactly one cycle per accepted `start`, and `busy` is 0 whenever `done` is 1. For two finite operands, `busy` is 1 from the cycle after `start` until completion.
- R8: A `start` pulse that arrives while `busy` is 1 is ignored. The result that follows is that of the operation already running.
- R9: `xr`, `yr`, `r_inf` and `same_pt` change only on the cycle where `done` is 1. Between completions they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an addition. Accepted only while idle |
| xp | input | WIDTH | x of first point, below p |
| yp | input | WIDTH | y of first point, below p |
| p_inf | input | 1 | First point is the point at infinity |
| xq | input | WIDTH | x of second point, below p |
| yq | input | WIDTH | y of second point, below p |
| q_inf | input | 1 | Second point is the point at infinity |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| xr | output | WIDTH | x of the sum |
| yr | output | WIDTH | y of the sum |
| r_inf | output | 1 | Sum is the point at infinity |
| same_pt | output | 1 | Operands are equal; doubling needed, no sum given |

## Verification
Several internal faults show up at the ports as a wrong affine sum in the same cycle that `done` rises. These include a mis-sequenced ALU step, a stale scratch register, or a wrong exponent bit in the inversion. Scanning every ordered pair of points on a small curve exposes them within one operation. A faulty equal-x test surfaces as a wrong flag on its first coincident pair. A control state that fails to return to idle shows as a missing `done`, which the bench treats as a failure after a bounded wait.

// File: rtl/jpa_pkg.sv
package jpa_pkg;

    localparam int NREG = 16;
    typedef logic [3:0] ridx_t;
    typedef logic [4:0] pc_t;

    typedef enum logic [1:0] {OP_MUL, OP_ADD, OP_SUB, OP_HALF} aop_t;

    typedef struct packed {
        aop_t  op;
        ridx_t dst;
        ridx_t sa;
        ridx_t sb;
    } uop_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PROG, ST_CHK, ST_INIT, ST_INV, ST_FIN, ST_OUT
    } st_t;

    // register slots
    localparam ridx_t RX1 = 4'd0,  RY1 = 4'd1,  RZ1 = 4'd2;
    localparam ridx_t RX2 = 4'd3,  RY2 = 4'd4,  RZ2 = 4'd5;
    localparam ridx_t RT  = 4'd6,  RU1 = 4'd7,  RS1 = 4'd8;
    localparam ridx_t RU2 = 4'd9,  RS2 = 4'd10, RW  = 4'd11;
    localparam ridx_t RR  = 4'd12, RZ3 = 4'd13, RX3 = 4'd14;
    localparam ridx_t RY3 = 4'd15;

    localparam pc_t PC_LAST1  = 5'd24;
    localparam pc_t PC_FIRST2 = 5'd25;
    localparam pc_t PC_LAST2  = 5'd28;

    function automatic uop_t mk(aop_t o, ridx_t d, ridx_t a, ridx_t b);
        uop_t u;
        u.op = o; u.dst = d; u.sa = a; u.sb = b;
        return u;
    endfunction

    // Steps 0..24: projective sum. Steps 25..28: affine conversion,
    // with Z3^-1 already in RT.
    function automatic uop_t prog_step(pc_t pc);
        case (pc)
            5'd0:  return mk(OP_MUL, RT,  RZ2, RZ2);
            5'd1:  return mk(OP_MUL, RU1, RX1, RT);
            5'd2:  return mk(OP_MUL, RT,  RT,  RZ2);
            5'd3:  return mk(OP_MUL, RS1, RY1, RT);
            5'd4:  return mk(OP_MUL, RT,  RZ1, RZ1);
            5'd5:  return mk(OP_MUL, RU2, RX2, RT);
            5'd6:  return mk(OP_MUL, RT,  RT,  RZ1);
            5'd7:  return mk(OP_MUL, RS2, RY2, RT);
            5'd8:  return mk(OP_SUB, RW,  RU1, RU2);
            5'd9:  return mk(OP_SUB, RR,  RS1, RS2);
            5'd10: return mk(OP_ADD, RU1, RU1, RU2);
            5'd11: return mk(OP_ADD, RS1, RS1, RS2);
            5'd12: return mk(OP_MUL, RU2, RZ1, RZ2);
            5'd13: return mk(OP_MUL, RZ3, RU2, RW);
            5'd14: return mk(OP_MUL, RT,  RW,  RW);
            5'd15: return mk(OP_MUL, RU2, RU1, RT);
            5'd16: return mk(OP_MUL, RS2, RR,  RR);
            5'd17: return mk(OP_SUB, RX3, RS2, RU2);
            5'd18: return mk(OP_ADD, RS2, RX3, RX3);
            5'd19: return mk(OP_SUB, RU2, RU2, RS2);
            5'd20: return mk(OP_MUL, RU2, RU2, RR);
            5'd21: return mk(OP_MUL, RT,  RT,  RW);
            5'd22: return mk(OP_MUL, RT,  RT,  RS1);
            5'd23: return mk(OP_SUB, RU2, RU2, RT);
            5'd24: return mk(OP_HALF, RY3, RU2, RU2);
            5'd25: return mk(OP_MUL, RU1, RT,  RT);
            5'd26: return mk(OP_MUL, RX1, RX3, RU1);
            5'd27: return mk(OP_MUL, RU1, RU1, RT);
            5'd28: return mk(OP_MUL, RY1, RY3, RU1);
            default: return mk(OP_MUL, RT, RT, RT);
        endcase
    endfunction

endpackage

// File: rtl/jpa_modalu.sv
module jpa_modalu
    import jpa_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int PRIME = 65521
) (
    input  aop_t             op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    localparam logic [2*WIDTH-1:0] PW   = (2*WIDTH)'(PRIME);
    localparam logic [WIDTH:0]     P1   = (WIDTH+1)'(PRIME);
    localparam logic [WIDTH-1:0]   HALF = WIDTH'((PRIME + 1) / 2);

    logic [2*WIDTH-1:0] prod;
    logic [WIDTH:0]     sum;
    logic [WIDTH:0]     dif;

    always_comb begin
        prod = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, (op == OP_HALF) ? HALF : b};
        sum  = {1'b0, a} + {1'b0, b};
        if (a >= b) dif = {1'b0, a} - {1'b0, b};
        else        dif = {1'b0, a} + P1 - {1'b0, b};
        case (op)
            OP_ADD:  y = (sum >= P1) ? WIDTH'(sum - P1) : WIDTH'(sum);
            OP_SUB:  y = WIDTH'(dif);
            default: y = WIDTH'(prod % PW);
        endcase
    end
endmodule

// File: rtl/jpa_regfile.sv
module jpa_regfile
    import jpa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [WIDTH-1:0] xp,
    input  logic [WIDTH-1:0] yp,
    input  logic [WIDTH-1:0] xq,
    input  logic [WIDTH-1:0] yq,
    input  logic             we,
    input  ridx_t            waddr,
    input  logic [WIDTH-1:0] wdata,
    input  ridx_t            ra,
    input  ridx_t            rb,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (ld) begin
                case (ridx_t'(i))
                    RX1:     regs[i] <= xp;
                    RY1:     regs[i] <= yp;
                    RX2:     regs[i] <= xq;
                    RY2:     regs[i] <= yq;
                    RZ1:     regs[i] <= ONE;
                    RZ2:     regs[i] <= ONE;
                    default: regs[i] <= '0;
                endcase
            end else if (we && waddr == ridx_t'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rd_a = regs[ra];
    assign rd_b = regs[rb];
endmodule

// File: rtl/jpa_ctrl.sv
module jpa_ctrl
    import jpa_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int PRIME = 65521
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] xp,
    input  logic [WIDTH-1:0] yp,
    input  logic             p_inf,
    input  logic [WIDTH-1:0] xq,
    input  logic [WIDTH-1:0] yq,
    input  logic             q_inf,
    input  logic [WIDTH-1:0] rd_a,
    input  logic [WIDTH-1:0] rd_b,
    output aop_t             alu_op,
    output ridx_t            ra,
    output ridx_t            rb,
    output logic             we,
    output ridx_t            waddr,
    output logic             wsel_one,
    output logic             ld,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] xr,
    output logic [WIDTH-1:0] yr,
    output logic             r_inf,
    output logic             same_pt
);
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [WIDTH-1:0] EXP  = WIDTH'(PRIME - 2);
    localparam logic [BW-1:0]    KTOP = BW'(WIDTH - 1);

    st_t          st;
    pc_t          pc;
    logic [BW-1:0] bitk;
    logic         ph;
    uop_t         u;

    assign busy = (st != ST_IDLE);

    always_comb begin
        u        = prog_step(pc);
        alu_op   = OP_MUL;
        ra       = RT;
        rb       = RT;
        we       = 1'b0;
        waddr    = RT;
        wsel_one = 1'b0;
        ld       = 1'b0;
        case (st)
            ST_IDLE: ld = start && !p_inf && !q_inf;
            ST_PROG, ST_FIN: begin
                alu_op = u.op; ra = u.sa; rb = u.sb;
                waddr  = u.dst; we = 1'b1;
            end
            ST_CHK:  begin ra = RW; rb = RR; end
            ST_INIT: begin we = 1'b1; wsel_one = 1'b1; end
            ST_INV: begin
                if (!ph) begin
                    we = 1'b1;
                end else begin
                    rb = RZ3;
                    we = EXP[bitk];
                end
            end
            ST_OUT:  begin ra = RX1; rb = RY1; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; pc <= '0; bitk <= '0; ph <= 1'b0;
            done <= 1'b0; xr <= '0; yr <= '0; r_inf <= 1'b0; same_pt <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    if (p_inf) begin
                        xr <= q_inf ? '0 : xq;
                        yr <= q_inf ? '0 : yq;
                        r_inf <= q_inf; same_pt <= 1'b0; done <= 1'b1;
                    end else if (q_inf) begin
                        xr <= xp; yr <= yp;
                        r_inf <= 1'b0; same_pt <= 1'b0; done <= 1'b1;
                    end else begin
                        st <= ST_PROG; pc <= '0;
                    end
                end
                ST_PROG: begin
                    if (pc == PC_LAST1) st <= ST_CHK;
                    else pc <= pc + 5'd1;
                end
                ST_CHK: begin
                    if (rd_a == '0) begin
                        xr <= '0; yr <= '0;
                        r_inf   <= (rd_b != '0);
                        same_pt <= (rd_b == '0);
                        done <= 1'b1; st <= ST_IDLE;
                    end else begin
                        st <= ST_INIT;
                    end
                end
                ST_INIT: begin
                    st <= ST_INV; bitk <= KTOP; ph <= 1'b0;
                end
                ST_INV: begin
                    if (!ph) begin
                        ph <= 1'b1;
                    end else if (bitk == '0) begin
                        st <= ST_FIN; pc <= PC_FIRST2;
                    end else begin
                        bitk <= bitk - 1'b1; ph <= 1'b0;
                    end
                end
                ST_FIN: begin
                    if (pc == PC_LAST2) st <= ST_OUT;
                    else pc <= pc + 5'd1;
                end
                ST_OUT: begin
                    xr <= rd_a; yr <= rd_b;
                    r_inf <= 1'b0; same_pt <= 1'b0;
                    done <= 1'b1; st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/jac_point_adder.sv
module jac_point_adder
    import jpa_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int PRIME = 65521
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] xp,
    input  logic [WIDTH-1:0] yp,
    input  logic             p_inf,
    input  logic [WIDTH-1:0] xq,
    input  logic [WIDTH-1:0] yq,
    input  logic             q_inf,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] xr,
    output logic [WIDTH-1:0] yr,
    output logic             r_inf,
    output logic             same_pt
);
    aop_t             alu_op;
    ridx_t            ra, rb, waddr;
    logic             we, wsel_one, ld;
    logic [WIDTH-1:0] rd_a, rd_b, alu_y, wdata;

    assign wdata = wsel_one ? WIDTH'(1) : alu_y;

    jpa_ctrl #(.WIDTH(WIDTH), .PRIME(PRIME)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .xp(xp), .yp(yp), .p_inf(p_inf), .xq(xq), .yq(yq), .q_inf(q_inf),
        .rd_a(rd_a), .rd_b(rd_b), .alu_op(alu_op), .ra(ra), .rb(rb),
        .we(we), .waddr(waddr), .wsel_one(wsel_one), .ld(ld),
        .busy(busy), .done(done), .xr(xr), .yr(yr),
        .r_inf(r_inf), .same_pt(same_pt)
    );

    jpa_regfile #(.WIDTH(WIDTH)) u_rf (
        .clk(clk), .rst(rst), .ld(ld),
        .xp(xp), .yp(yp), .xq(xq), .yq(yq),
        .we(we), .waddr(waddr), .wdata(wdata),
        .ra(ra), .rb(rb), .rd_a(rd_a), .rd_b(rd_b)
    );

    jpa_modalu #(.WIDTH(WIDTH), .PRIME(PRIME)) u_alu (
        .op(alu_op), .a(rd_a), .b(rd_b), .y(alu_y)
    );
endmodule

// File: rtl/jpa_chk.sv
module jpa_chk #(
    parameter int WIDTH = 16,
    parameter int PRIME = 65521
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] xr,
    input logic [WIDTH-1:0] yr,
    input logic             r_inf,
    input logic             same_pt
);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(xr) && $stable(yr) && $stable(r_inf) && $stable(same_pt)));

    assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(r_inf && same_pt));

    assert_equal_zero_R6: assert property (@(posedge clk) disable iff (rst)
        same_pt |-> (xr == '0 && yr == '0));

    assert_inf_zero_R5: assert property (@(posedge clk) disable iff (rst)
        r_inf |-> (xr == '0 && yr == '0));

    assert_reduced_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(xr) < PRIME && int'(yr) < PRIME));
endmodule

bind jac_point_adder jpa_chk #(.WIDTH(WIDTH), .PRIME(PRIME)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .xr(xr), .yr(yr), .r_inf(r_inf), .same_pt(same_pt)
);

// File: tb/sim_jac_point_adder.sv
`timescale 1ns/1ps
module sim_jac_point_adder;
    localparam int W = 5;
    localparam int P = 23;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [W-1:0] xp = '0, yp = '0, xq = '0, yq = '0;
    logic p_inf = 1'b0, q_inf = 1'b0;
    logic busy, done, r_inf, same_pt;
    logic [W-1:0] xr, yr;

    int checks = 0;
    int fails = 0;
    int px [32];
    int py [32];
    int npts = 0;

    always #2.5 clk = ~clk;

    jac_point_adder #(.WIDTH(W), .PRIME(P)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .xp(xp), .yp(yp), .p_inf(p_inf), .xq(xq), .yq(yq), .q_inf(q_inf),
        .busy(busy), .done(done), .xr(xr), .yr(yr),
        .r_inf(r_inf), .same_pt(same_pt)
    );

    function automatic int md(int v);
        return ((v % P) + P) % P;
    endfunction

    function automatic int inv(int a);
        for (int k = 1; k < P; k++) if (md(a * k) == 1) return k;
        return 0;
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_done(string req, output int lat);
        int n = 0;
        do begin @(negedge clk); n++; end while (!done && n < 400);
        lat = n;
        if (!done) chk({req, " timeout"}, 0, 1);
    endtask

    task automatic run_pair(int i, int j);
        bit pi, qi;
        int ex, ey, einf, esame, lat;
        string req;
        pi = (i == npts); qi = (j == npts);
        einf = 0; esame = 0; ex = 0; ey = 0;
        if (pi && qi) begin einf = 1; req = "R4"; end
        else if (pi) begin ex = px[j]; ey = py[j]; req = "R3"; end
        else if (qi) begin ex = px[i]; ey = py[i]; req = "R4"; end
        else if (px[i] == px[j]) begin
            if (py[i] == py[j]) begin esame = 1; req = "R6"; end
            else begin einf = 1; req = "R5"; end
        end else begin
            int lam;
            lam = md(md(py[j] - py[i]) * inv(md(px[j] - px[i])));
            ex = md(lam * lam - px[i] - px[j]);
            ey = md(lam * (px[i] - ex) - py[i]);
            req = "R2";
        end
        @(negedge clk);
        xp = pi ? '0 : W'(px[i]); yp = pi ? '0 : W'(py[i]); p_inf = pi;
        xq = qi ? '0 : W'(px[j]); yq = qi ? '0 : W'(py[j]); q_inf = qi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (pi || qi) begin
            chk({req, " fast done"}, int'(done), 1);
        end else begin
            chk("R7 busy", int'(busy), 1);
            wait_done(req, lat);
        end
        chk({req, " flags"}, {int'(r_inf), int'(same_pt)} == {einf, esame} ? 1 : 0, 1);
        chk({req, " xr"}, int'(xr), ex);
        chk({req, " yr"}, int'(yr), ey);
        @(negedge clk);
        chk("R7 single pulse", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lat, hx, hy;
        // points of y^2 = x^3 + x + 1 over GF(23)
        for (int x = 0; x < P; x++)
            for (int y = 0; y < P; y++)
                if (md(y * y) == md(x * x * x + x + 1)) begin
                    px[npts] = x; py[npts] = y; npts++;
                end
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 out", int'(xr) + int'(yr) + int'(r_inf) + int'(same_pt), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", int'(busy) + int'(done) + int'(xr) + int'(yr), 0);

        for (int i = 0; i <= npts; i++)
            for (int j = 0; j <= npts; j++)
                run_pair(i, j);

        // R8: second start during an operation is ignored
        @(negedge clk);
        xp = W'(px[0]); yp = W'(py[0]); xq = W'(px[3]); yq = W'(py[3]);
        p_inf = 1'b0; q_inf = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        xp = W'(px[5]); yp = W'(py[5]); xq = W'(px[7]); yq = W'(py[7]); start = 1'b1;
        @(negedge clk); start = 1'b0;
        begin
            int lam, ex, ey;
            lam = md(md(py[3] - py[0]) * inv(md(px[3] - px[0])));
            ex = md(lam * lam - px[0] - px[3]);
            ey = md(lam * (px[0] - ex) - py[0]);
            wait_done("R8", lat);
            chk("R8 xr", int'(xr), ex);
            chk("R8 yr", int'(yr), ey);
            hx = ex; hy = ey;
        end
        // R9: outputs hold while idle with changing inputs
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            xp = W'(k); yq = W'(k + 3);
        end
        chk("R9 xr hold", int'(xr), hx);
        chk("R9 yr hold", int'(yr), hy);
        chk("R9 flags hold", int'(r_inf) + int'(same_pt), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule